// File: doc/BRIEF.md
# Queued Invalidation Descriptor Engine

This block walks a circular queue of 16-byte invalidation descriptors held in memory. Software programs the queue base, writes the tail offset, and sets a queue-enable command level. While enabled, the engine reads the slot at the head offset and decodes it. A descriptor can be a cache, IOTLB or interrupt-entry invalidation, which raises a one-cycle pulse. It can also be a wait descriptor, which can write a 32-bit status word back to memory. After each slot the head moves on by one slot. The head wraps at the end of the queue.

A malformed descriptor raises a sticky queue-error flag. The head then stays on the offending slot and nothing more is fetched. Software repairs the slot and clears the flag by pulsing a write-one-to-clear input, and the engine refetches the same slot. Memory is reached through one read port and one write port, each a simple request/ack pair.

The controller has five states. OFF holds head at zero and reports disabled. IDLE is enabled and waits for work. FETCH holds the read request until ack. DECODE classifies the latched descriptor for one cycle. WSTAT holds the status write until ack. The transitions are:
- OFF→IDLE when the command is high.
- IDLE→OFF when the command is low.
- IDLE→FETCH when head differs from tail and no error is pending.
- FETCH→DECODE on read ack.
- DECODE→WSTAT for a wait descriptor with the write flag set.
- DECODE→IDLE otherwise.
- WSTAT→IDLE on write ack.

Top module: `qinv_engine`

## Requirements
- R1: After reset, status enable is 0, head and tail read 0, the error flag is 0, and neither memory request is raised.
- R2: With the enable command high, the status output reads 1 one cycle after OFF is left. With the command low and the engine idle, the status drops in the next cycle, and head reads 0 one cycle later.
- R3: While status enable is 0, no read request is raised and head stays 0, even when tail is nonzero.
- R4: Slots are fetched in order from address base+head. Head advances by 16 after each completed slot and wraps modulo SLOTS*16, so with 16 slots the head goes from 0xF0 to 0x00.
- R5: Type code 1, 2 or 4 in bits 3:0 of the low word raises exactly one one-cycle pulse, on the context-cache, IOTLB or interrupt-entry output respectively.
- R6: A wait descriptor has type 5, with bit 5 of the low word set and bits 31:6 and bit 4 zero. It writes low-word bits 63:32 to the 64-bit address held in the high word, and head advances only after the write ack.
- R7: A wait descriptor with bit 5 clear writes nothing and completes.
- R8: Any other type code is invalid. So is a wait descriptor with nonzero reserved bits. Either one sets the error flag, leaves head on that slot, and stops further fetches.
- R9: A one-cycle pulse on the clear input drops the error flag in the next cycle, and fetching resumes from the same slot. If a new error is detected in the same cycle, setting wins.
- R10: Tail writes ignore the low 4 bits of the written value, so tail always reads as a multiple of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_qen | input | 1 | Queue-enable command level |
| sts_qen | output | 1 | Queue-enabled status |
| q_base | input | AW | Queue base byte address |
| tail_we | input | 1 | Tail write strobe |
| tail_wdata | input | OFFS_W | New tail byte offset |
| tail_q | output | OFFS_W | Current tail offset |
| head_q | output | OFFS_W | Current head offset |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| err_flag | output | 1 | Invalid-descriptor error flag |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | AW | Descriptor read address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 128 | Descriptor, high word in bits 127:64 |
| wr_req | output | 1 | Status write request |
| wr_addr | output | 64 | Status write address |
| wr_data | output | 32 | Status word |
| wr_ack | input | 1 | Write acknowledge |
| ctx_done | output | 1 | Context-cache invalidation pulse |
| iotlb_done | output | 1 | IOTLB invalidation pulse |
| iec_done | output | 1 | Interrupt-entry-cache invalidation pulse |

## Verification
The pulses for invalidation descriptors appear in the DECODE cycle, one edge after the read ack is seen. The status write request appears one cycle after that. The bench's memory model acks each request one cycle after it is raised. A monitor samples every pulse and every acknowledged write on the falling edge and compares it against the scoreboard queue filled by the driver. Status and error flags are checked at exact falling edges: one after the enable or clear change for the status and error flags, and two after disable for head. Head positions are checked by polling until the expected offset is reached within a bounded number of cycles.

// File: rtl/qinv_pkg.sv
package qinv_pkg;
    typedef enum logic [2:0] {S_OFF, S_IDLE, S_FETCH, S_DECODE, S_WSTAT} qi_state_e;
    typedef enum logic [2:0] {K_CTX, K_IOTLB, K_IEC, K_WAIT, K_BAD} qi_kind_e;

    localparam logic [3:0] TYPE_CTX   = 4'h1;
    localparam logic [3:0] TYPE_IOTLB = 4'h2;
    localparam logic [3:0] TYPE_IEC   = 4'h4;
    localparam logic [3:0] TYPE_WAIT  = 4'h5;
    localparam int         SW_FLAG_BIT = 5;
    localparam int         SLOT_BYTES_LOG2 = 4;
endpackage

// File: rtl/qinv_decode.sv
module qinv_decode
    import qinv_pkg::*;
(
    input  logic [63:0] desc_lo,
    output qi_kind_e    kind,
    output logic        status_wr,
    output logic [31:0] status_word
);
    logic rsvd_nz;

    // reserved fields of a wait descriptor: bit 4 and bits 31:6
    assign rsvd_nz     = desc_lo[4] | (|desc_lo[31:6]);
    assign status_wr   = desc_lo[SW_FLAG_BIT];
    assign status_word = desc_lo[63:32];

    always_comb begin
        unique case (desc_lo[3:0])
            TYPE_CTX:   kind = K_CTX;
            TYPE_IOTLB: kind = K_IOTLB;
            TYPE_IEC:   kind = K_IEC;
            TYPE_WAIT:  kind = rsvd_nz ? K_BAD : K_WAIT;
            default:    kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/qinv_ptrs.sv
module qinv_ptrs
    import qinv_pkg::*;
#(
    parameter int OFFS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tail_we,
    input  logic [OFFS_W-1:0] tail_wdata,
    input  logic              head_clr,
    input  logic              head_adv,
    output logic [OFFS_W-1:0] head,
    output logic [OFFS_W-1:0] tail
);
    localparam logic [OFFS_W-1:0] STEP = OFFS_W'(1 << SLOT_BYTES_LOG2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail <= '0;
        end else if (tail_we) begin
            tail <= {tail_wdata[OFFS_W-1:SLOT_BYTES_LOG2], {SLOT_BYTES_LOG2{1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head <= '0;
        end else if (head_clr) begin
            head <= '0;
        end else if (head_adv) begin
            head <= head + STEP;   // natural wrap modulo SLOTS*16
        end
    end
endmodule

// File: rtl/qinv_engine.sv
module qinv_engine
    import qinv_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int AW     = 64,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int OFFS_W = SLOT_W + SLOT_BYTES_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_qen,
    output logic              sts_qen,
    input  logic [AW-1:0]     q_base,
    input  logic              tail_we,
    input  logic [OFFS_W-1:0] tail_wdata,
    output logic [OFFS_W-1:0] tail_q,
    output logic [OFFS_W-1:0] head_q,
    input  logic              err_clr,
    output logic              err_flag,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_ack,
    input  logic [127:0]      rd_data,
    output logic              wr_req,
    output logic [63:0]       wr_addr,
    output logic [31:0]       wr_data,
    input  logic              wr_ack,
    output logic              ctx_done,
    output logic              iotlb_done,
    output logic              iec_done
);
    qi_state_e   state, nxt;
    logic [127:0] desc_q;
    qi_kind_e    kind;
    logic        status_wr;
    logic [31:0] status_word;
    logic        head_clr, head_adv, err_set;

    qinv_decode u_dec (
        .desc_lo     (desc_q[63:0]),
        .kind        (kind),
        .status_wr   (status_wr),
        .status_word (status_word)
    );

    qinv_ptrs #(.OFFS_W(OFFS_W)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .tail_we    (tail_we),
        .tail_wdata (tail_wdata),
        .head_clr   (head_clr),
        .head_adv   (head_adv),
        .head       (head_q),
        .tail       (tail_q)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:    if (cmd_qen) nxt = S_IDLE;
            S_IDLE:   if (!cmd_qen) nxt = S_OFF;
                      else if (!err_flag && (head_q != tail_q)) nxt = S_FETCH;
            S_FETCH:  if (rd_ack) nxt = S_DECODE;
            S_DECODE: nxt = (kind == K_WAIT && status_wr) ? S_WSTAT : S_IDLE;
            S_WSTAT:  if (wr_ack) nxt = S_IDLE;
            default:  nxt = S_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    // descriptor latch and sticky error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q   <= '0;
            err_flag <= 1'b0;
        end else begin
            if (state == S_FETCH && rd_ack) desc_q <= rd_data;
            if (err_set)      err_flag <= 1'b1;
            else if (err_clr) err_flag <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        sts_qen    = (state != S_OFF);
        rd_req     = (state == S_FETCH);
        wr_req     = (state == S_WSTAT);
        rd_addr    = q_base + AW'(head_q);
        wr_addr    = desc_q[127:64];
        wr_data    = status_word;
        ctx_done   = (state == S_DECODE) && (kind == K_CTX);
        iotlb_done = (state == S_DECODE) && (kind == K_IOTLB);
        iec_done   = (state == S_DECODE) && (kind == K_IEC);
        err_set    = (state == S_DECODE) && (kind == K_BAD);
        head_clr   = (state == S_OFF);
        head_adv   = ((state == S_DECODE) && (kind != K_BAD) && !(kind == K_WAIT && status_wr))
                   || ((state == S_WSTAT) && wr_ack);
    end

    assert_pulse_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctx_done, iotlb_done, iec_done}));
    assert_no_fetch_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_qen |-> !rd_req);
    assert_sts_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_qen) |-> $past(cmd_qen));
    assert_err_no_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && $past(err_flag)) |-> !rd_req);
    assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
    assert_head_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_qen && $past(sts_qen) && (head_q != $past(head_q)))
        |-> (head_q == OFFS_W'($past(head_q) + OFFS_W'(16))));
endmodule

// File: tb/tb_qinv_engine.sv
module tb_qinv_engine;
    localparam int SLOTS = 16;
    localparam int AW = 64;
    localparam int OFFS_W = $clog2(SLOTS) + 4;
    localparam logic [AW-1:0] BASE = 64'h1000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_qen = 0, tail_we = 0, err_clr = 0, rd_ack = 0, wr_ack = 0;
    logic [OFFS_W-1:0] tail_wdata = '0;
    logic [127:0] rd_data = '0;
    logic sts_qen, err_flag, rd_req, wr_req, ctx_done, iotlb_done, iec_done;
    logic [OFFS_W-1:0] tail_q, head_q;
    logic [AW-1:0] rd_addr;
    logic [63:0] wr_addr;
    logic [31:0] wr_data;

    always #5 clk = ~clk;

    qinv_engine #(.SLOTS(SLOTS), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_qen(cmd_qen), .sts_qen(sts_qen),
        .q_base(BASE), .tail_we(tail_we), .tail_wdata(tail_wdata),
        .tail_q(tail_q), .head_q(head_q), .err_clr(err_clr), .err_flag(err_flag),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .ctx_done(ctx_done), .iotlb_done(iotlb_done), .iec_done(iec_done));

    logic [127:0] mem [SLOTS];
    int checks = 0, fails = 0, rd_count = 0;

    typedef struct { int kind; logic [63:0] addr; logic [31:0] data; string req; } exp_t;
    exp_t exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic push(input int kind, input logic [63:0] addr, input logic [31:0] data,
                        input string req);
        exp_t e;
        e.kind = kind; e.addr = addr; e.data = data; e.req = req;
        exp_q.push_back(e);
    endtask

    function automatic logic [127:0] inv_desc(input logic [3:0] t);
        return {64'h0, 60'h0, t};
    endfunction

    function automatic logic [127:0] wait_desc(input bit flag, input logic [31:0] d,
                                               input logic [63:0] a);
        return {a, d, 26'h0, flag, 1'b0, 4'h5};
    endfunction

    // memory model: ack one cycle after request
    always @(posedge clk) begin
        rd_ack  <= rd_req && !rd_ack;
        rd_data <= mem[4'((rd_addr - BASE) >> 4)];
        wr_ack  <= wr_req && !wr_ack;
    end

    // scoreboard monitor
    task automatic observe(input int kind, input logic [63:0] a, input logic [31:0] d);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(0, "R5/R6/R7", "unexpected event kind", 64'(kind), 64'h0);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == kind, e.req, "event kind", 64'(kind), 64'(e.kind));
            if (kind == 4) begin
                check(a == e.addr, e.req, "status addr", a, e.addr);
                check(d == e.data, e.req, "status data", 64'(d), 64'(e.data));
            end
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        if (rd_req && !sts_qen) rd_count++;
        if (ctx_done)   observe(1, 0, 0);
        if (iotlb_done) observe(2, 0, 0);
        if (iec_done)   observe(3, 0, 0);
        if (wr_req && wr_ack) observe(4, wr_addr, wr_data);
    end

    task automatic set_tail(input logic [OFFS_W-1:0] v);
        @(negedge clk); tail_wdata = v; tail_we = 1;
        @(negedge clk); tail_we = 0;
    endtask

    task automatic wait_head(input logic [OFFS_W-1:0] v, input string req);
        for (int i = 0; i < 400 && head_q != v; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(head_q == v, req, "head", 64'(head_q), 64'(v));
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", "timeout", 0, 0);
        finish_up();
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(sts_qen == 0, "R1", "sts", 64'(sts_qen), 0);
        check(head_q == 0 && tail_q == 0, "R1", "head/tail", 64'({head_q, tail_q}), 0);
        check(err_flag == 0 && !rd_req && !wr_req, "R1", "err/req",
              64'({err_flag, rd_req, wr_req}), 0);

        // R3 no fetch while disabled
        set_tail(8'h20);
        repeat (10) @(negedge clk);
        check(rd_count == 0 && head_q == 0, "R3", "fetch while off",
              64'(rd_count), 0);
        set_tail(8'h00);

        // R2 enable handshake
        cmd_qen = 1;
        @(negedge clk);
        check(sts_qen == 1, "R2", "sts rise", 64'(sts_qen), 1);

        // R4 R5 R6 R10
        mem[0] = inv_desc(4'h1); push(1, 0, 0, "R5");
        mem[1] = inv_desc(4'h2); push(2, 0, 0, "R5");
        mem[2] = inv_desc(4'h4); push(3, 0, 0, "R5");
        mem[3] = wait_desc(1, 32'hA5A5_0001, 64'h0000_0002_0000_0200);
        push(4, 64'h0000_0002_0000_0200, 32'hA5A5_0001, "R6");
        set_tail(8'h43);
        check(tail_q == 8'h40, "R10", "tail low bits", 64'(tail_q), 64'h40);
        wait_head(8'h40, "R4");

        // R7 wait without write flag
        mem[4] = wait_desc(0, 32'hDEAD_BEEF, 64'h300);
        mem[5] = inv_desc(4'h1); push(1, 0, 0, "R7");
        set_tail(8'h60);
        wait_head(8'h60, "R7");

        // R8 invalid descriptor halts
        mem[6] = inv_desc(4'h1); push(1, 0, 0, "R8");
        mem[7] = inv_desc(4'h7);
        mem[8] = inv_desc(4'h4);
        set_tail(8'h90);
        repeat (40) @(negedge clk);
        check(err_flag == 1, "R8", "err flag", 64'(err_flag), 1);
        check(head_q == 8'h70, "R8", "head frozen", 64'(head_q), 64'h70);

        // R9 clear and resume at the same slot
        mem[7] = inv_desc(4'h2); push(2, 0, 0, "R9");
        push(3, 0, 0, "R9");
        err_clr = 1;
        @(negedge clk);
        err_clr = 0;
        check(err_flag == 0, "R9", "err cleared", 64'(err_flag), 0);
        wait_head(8'h90, "R9");

        // R8 reserved bits in a wait descriptor
        mem[9] = {64'h400, 32'h1, 26'h1, 1'b1, 1'b0, 4'h5};
        set_tail(8'hA0);
        repeat (30) @(negedge clk);
        check(err_flag == 1 && head_q == 8'h90, "R8", "reserved wait",
              64'({err_flag, head_q}), 64'h190);
        mem[9] = inv_desc(4'h1); push(1, 0, 0, "R4");
        err_clr = 1;
        @(negedge clk);
        err_clr = 0;

        // R4 wrap
        for (int s = 10; s < SLOTS; s++) begin
            mem[s] = inv_desc(4'h1); push(1, 0, 0, "R4");
        end
        mem[0] = inv_desc(4'h2); push(2, 0, 0, "R4");
        mem[1] = inv_desc(4'h2); push(2, 0, 0, "R4");
        set_tail(8'h20);
        wait_head(8'h20, "R4");

        // R2 disable
        cmd_qen = 0;
        @(negedge clk);
        check(sts_qen == 0, "R2", "sts drop", 64'(sts_qen), 0);
        @(negedge clk);
        check(head_q == 0, "R2", "head cleared", 64'(head_q), 0);
        check(exp_q.size() == 0, "R6", "missing events", 64'(exp_q.size()), 0);
        finish_up();
    end
endmodule